// File: doc/BRIEF.md
# Rounding Shift-Right Accumulate Unit

This block shifts every lane of a 128-bit source vector right by an immediate amount. Lanes are 8, 16, 32 or 64 bits wide. Four independent mode pins choose the variant. The signed pin selects an arithmetic rather than a logical shift. The round pin adds half of the last kept bit before the shift. The accumulate pin adds the shifted lane into the matching lane of the old destination vector. The scalar pin restricts the operation to lane 0 alone. All four pins may be set in any combination.

A register-width pin selects whether the register holds 64 or 128 bits. The lane count is the register width divided by the lane width in vector mode, and it is exactly one in scalar mode. Every result bit outside the lanes that were processed is zero. This means the upper 64 bits are cleared when the register is 64 bits wide or when the operation is scalar.

Operations enter on a valid/ready stream and leave on a second valid/ready stream through a single register stage. A transfer happens on a clock edge where valid and ready are both high. The input ready is high whenever the output register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the result waits in the register and new input is refused.

Top module: `vsra_unit`

## Requirements
- R1: With `sgn_mode`=1 each lane is sign-extended and shifted arithmetically. With `sgn_mode`=0 each lane is zero-extended and shifted logically.
- R2: With `rnd_mode`=1 the value 2^(shift-1) is added to the extended lane before the shift, with no loss of the carry. This also holds for 64-bit lanes.
- R3: With `acc_mode`=1 the shifted lane is added to the same lane of `dst_vec`, and the sum wraps to the lane width.
- R4: `lane_size` codes 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit lanes. In vector mode the lane count is 128/width when `wide_reg`=1 and 64/width when `wide_reg`=0. Lanes never carry into each other.
- R5: With `scalar_mode`=1 only lane 0 (bits width-1:0) is computed, and every other result bit is zero.
- R6: Result bits 127:64 are zero when `wide_reg`=0 or `scalar_mode`=1.
- R7: A shift equal to the lane width gives 0 for an unsigned lane and all sign bits for a signed lane, before the rounding carry and the accumulation are applied.
- R8: An input accepted on a clock edge is presented with `out_valid`=1 right after the next clock edge.
- R9: While `out_valid`=1 and `out_ready`=0, `out_vec` stays stable, `out_valid` stays high and `in_ready` is low.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.
- R11: While `in_valid`=1, `shift_amt` must be in the range 1 to the lane width (8 << `lane_size`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input operation valid |
| in_ready | output | 1 | Unit can accept an operation |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Old destination vector (accumulate operand) |
| lane_size | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| wide_reg | input | 1 | 1 = 128-bit register, 0 = 64-bit register |
| scalar_mode | input | 1 | Operate on lane 0 only |
| sgn_mode | input | 1 | Signed (arithmetic) shift |
| rnd_mode | input | 1 | Round before shifting |
| acc_mode | input | 1 | Accumulate into destination lane |
| shift_amt | input | 7 | Right-shift amount, 1 to lane width |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_vec | output | 128 | New destination vector |

## Verification
The assertions check the stream rules on every cycle: the one-cycle latency, the holding of the result under back-pressure, and the refusal of input while the result is stalled. They also check the legal shift range on each input. Also on every cycle, they check that the upper half is zeroed for scalar and 64-bit operations, that an 8-bit scalar operation leaves only its low byte, and that an unsigned, unrounded full-width shift gives zero. The lane arithmetic cannot be shown by any per-cycle property. This covers the extension, the rounding carry, the wrapping accumulate, the lane count and the isolation between lanes, and only the bench's sweeps show it. The bench sweeps every byte value under all sixteen mode combinations, every 8-bit shift and both register widths. It then runs randomized patterns with endpoint shifts for the wider lanes, and compares each result against an arithmetic model.

// File: rtl/vsra_pkg.sv
package vsra_pkg;
  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE  = 8;
  localparam int MAX_LANE  = MIN_LANE << (NUM_SIZES - 1);
  localparam int SHIFT_W   = $clog2(MAX_LANE) + 1;

  typedef struct packed {
    logic scalar;
    logic sgn;
    logic rnd;
    logic acc;
  } vsra_mode_t;

  function automatic int lane_bits(input logic [1:0] code);
    return MIN_LANE << code;
  endfunction
endpackage

// File: rtl/vsra_lane.sv
module vsra_lane #(
  parameter int LW      = 8,
  parameter int SHIFT_W = 7
) (
  input  logic [LW-1:0]      src,
  input  logic [LW-1:0]      dst,
  input  logic [SHIFT_W-1:0] sh,
  input  logic               sgn,
  input  logic               rnd,
  input  logic               acc,
  output logic [LW-1:0]      res
);
  // two guard bits keep the rounding carry of any lane width
  localparam int XW = LW + 2;

  logic signed [XW-1:0] ext;
  logic signed [XW-1:0] half;
  logic signed [XW-1:0] biased;
  logic signed [XW-1:0] moved;
  logic [LW-1:0]        kept;

  always_comb begin
    ext  = {{2{sgn & src[LW-1]}}, src};
    half = '0;
    if (rnd && (sh != '0))
      half = {{(XW-1){1'b0}}, 1'b1} << (sh - SHIFT_W'(1));
    biased = ext + half;
    moved  = biased >>> sh;
    kept   = moved[LW-1:0];
    res    = acc ? (kept + dst) : kept;
  end
endmodule

// File: rtl/vsra_lane_array.sv
module vsra_lane_array #(
  parameter int VEC_W   = 128,
  parameter int LW      = 8,
  parameter int SHIFT_W = 7
) (
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W-1:0]   dst,
  input  logic [SHIFT_W-1:0] sh,
  input  logic               sgn,
  input  logic               rnd,
  input  logic               acc,
  output logic [VEC_W-1:0]   res
);
  localparam int NL = VEC_W / LW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    vsra_lane #(.LW(LW), .SHIFT_W(SHIFT_W)) u_lane (
      .src (src[g*LW +: LW]),
      .dst (dst[g*LW +: LW]),
      .sh  (sh),
      .sgn (sgn),
      .rnd (rnd),
      .acc (acc),
      .res (res[g*LW +: LW])
    );
  end
endmodule

// File: rtl/vsra_core.sv
module vsra_core
  import vsra_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W-1:0]   dst,
  input  logic [1:0]         size,
  input  logic               wide,
  input  vsra_mode_t         mode,
  input  logic [SHIFT_W-1:0] sh,
  output logic [VEC_W-1:0]   res
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] by_size [NUM_SIZES];
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] keep;
  int               keep_w;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    vsra_lane_array #(
      .VEC_W   (VEC_W),
      .LW      (MIN_LANE << k),
      .SHIFT_W (SHIFT_W)
    ) u_arr (
      .src (src),
      .dst (dst),
      .sh  (sh),
      .sgn (mode.sgn),
      .rnd (mode.rnd),
      .acc (mode.acc),
      .res (by_size[k])
    );
  end

  always_comb begin
    picked = by_size[size];
    if (mode.scalar)  keep_w = lane_bits(size);
    else if (!wide)   keep_w = HALF_W;
    else              keep_w = VEC_W;
    for (int b = 0; b < VEC_W; b++)
      keep[b] = (b < keep_w);
    res = picked & keep;
  end
endmodule

// File: rtl/vsra_unit.sv
module vsra_unit
  import vsra_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [VEC_W-1:0]   dst_vec,
  input  logic [1:0]         lane_size,
  input  logic               wide_reg,
  input  logic               scalar_mode,
  input  logic               sgn_mode,
  input  logic               rnd_mode,
  input  logic               acc_mode,
  input  logic [SHIFT_W-1:0] shift_amt,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [VEC_W-1:0]   out_vec
);
  vsra_mode_t       mode;
  logic [VEC_W-1:0] next_vec;
  logic             take;

  assign mode     = '{scalar: scalar_mode, sgn: sgn_mode, rnd: rnd_mode, acc: acc_mode};
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  vsra_core #(.VEC_W(VEC_W)) u_core (
    .src  (src_vec),
    .dst  (dst_vec),
    .size (lane_size),
    .wide (wide_reg),
    .mode (mode),
    .sh   (shift_amt),
    .res  (next_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_vec   <= next_vec;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsra_unit_chk.sv
module vsra_unit_chk #(
  parameter int VEC_W   = 128,
  parameter int SHIFT_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [1:0]         lane_size,
  input logic               wide_reg,
  input logic               scalar_mode,
  input logic               sgn_mode,
  input logic               rnd_mode,
  input logic               acc_mode,
  input logic [SHIFT_W-1:0] shift_amt,
  input logic               out_valid,
  input logic               out_ready,
  input logic [VEC_W-1:0]   out_vec
);
  logic fire;
  logic [SHIFT_W-1:0] full_w;
  assign fire   = in_valid && in_ready;
  assign full_w = SHIFT_W'(8) << lane_size;

  // R8
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

  // R9
  a_r9_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (scalar_mode || !wide_reg)) |=> (out_vec[VEC_W-1:VEC_W/2] == '0));

  // R5
  a_r5_scalar_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && scalar_mode && lane_size == 2'd0) |=> (out_vec[VEC_W-1:8] == '0));

  // R7
  a_r7_full_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !sgn_mode && !rnd_mode && !acc_mode && shift_amt == full_w) |=> (out_vec == '0));

  // R11
  a_r11_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (shift_amt != '0 && shift_amt <= full_w));
endmodule

bind vsra_unit vsra_unit_chk #(.VEC_W(VEC_W), .SHIFT_W(vsra_pkg::SHIFT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .lane_size   (lane_size),
  .wide_reg    (wide_reg),
  .scalar_mode (scalar_mode),
  .sgn_mode    (sgn_mode),
  .rnd_mode    (rnd_mode),
  .acc_mode    (acc_mode),
  .shift_amt   (shift_amt),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_vec     (out_vec)
);

// File: tb/vsra_unit_bench.sv
`timescale 1ns/1ps
module vsra_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] src_vec = '0;
  logic [127:0] dst_vec = '0;
  logic [1:0]   lane_size = '0;
  logic         wide_reg = 1'b1;
  logic         scalar_mode = 1'b0;
  logic         sgn_mode = 1'b0;
  logic         rnd_mode = 1'b0;
  logic         acc_mode = 1'b0;
  logic [6:0]   shift_amt = 7'd1;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_vec;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vsra_unit u_vsra_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_vec(src_vec), .dst_vec(dst_vec), .lane_size(lane_size), .wide_reg(wide_reg),
    .scalar_mode(scalar_mode), .sgn_mode(sgn_mode), .rnd_mode(rnd_mode),
    .acc_mode(acc_mode), .shift_amt(shift_amt), .out_valid(out_valid),
    .out_ready(out_ready), .out_vec(out_vec)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // arithmetic model of one lane: floor((value + bias) / 2^sh), then optional wrap-add
  function automatic logic [63:0] lane_model(input logic [63:0] s, input logic [63:0] d,
      input int lw, input bit sg, input bit rn, input bit ac, input int sh);
    logic [63:0] m;
    logic signed [71:0] v, t, p, q;
    logic [63:0] r;
    m = (lw == 64) ? '1 : ((64'h1 << lw) - 64'h1);
    v = 72'(s & m);
    if (sg && s[lw-1]) v = v - (72'sh1 <<< lw);
    p = 72'sh1 <<< sh;
    t = v + (rn ? (p / 2) : 72'sh0);
    if (t >= 0) q = t / p;
    else        q = -((-t + p - 1) / p);
    r = q[63:0] & m;
    if (ac) r = (r + d) & m;
    return r;
  endfunction

  function automatic logic [127:0] vec_model(input logic [127:0] s, input logic [127:0] d,
      input int size, input bit wide, input bit sc, input bit sg, input bit rn, input bit ac,
      input int sh);
    logic [127:0] res;
    int lw, nl;
    res = '0;
    lw = 8 << size;
    nl = sc ? 1 : ((wide ? 128 : 64) / lw);
    for (int i = 0; i < nl; i++) begin
      logic [63:0] l;
      l = lane_model(64'(s >> (i*lw)), 64'(d >> (i*lw)), lw, sg, rn, ac, sh);
      res = res | (128'(l) << (i*lw));
    end
    return res;
  endfunction

  task automatic run_op(input logic [127:0] s, input logic [127:0] d, input int size,
      input bit wide, input bit sc, input bit sg, input bit rn, input bit ac, input int sh,
      input string tag);
    @(negedge clk);
    src_vec = s; dst_vec = d; lane_size = 2'(size); wide_reg = wide;
    scalar_mode = sc; sgn_mode = sg; rnd_mode = rn; acc_mode = ac; shift_amt = 7'(sh);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 out_valid", {127'd0, out_valid}, 128'd1);
    check(tag, out_vec, vec_model(s, d, size, wide, sc, sg, rn, ac, sh));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", {127'd0, out_valid}, 128'd0);
    check("R10 in_ready", {127'd0, in_ready}, 128'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // byte lanes: every value, every shift, every mode, both widths (R1..R7, legal R11 shifts)
    for (int b = 0; b < 16; b++) begin
      logic [127:0] s, d;
      for (int i = 0; i < 16; i++) begin
        s[i*8 +: 8] = 8'(b + i*16);
        d[i*8 +: 8] = 8'(b*37 + i*91);
      end
      for (int sh = 1; sh <= 8; sh++)
        for (int m = 0; m < 16; m++)
          for (int w = 0; w < 2; w++)
            run_op(s, d, 0, w[0], m[3], m[2], m[1], m[0], sh, "R1 R2 R3 R4 R5 R6 R7 R11 byte");
    end

    // wider lanes: random patterns, endpoint shifts
    for (int size = 1; size < 4; size++)
      for (int n = 0; n < 256; n++) begin
        int lw, sh;
        logic [127:0] s;
        lw = 8 << size;
        case (n % 4)
          0: sh = 1;
          1: sh = lw;
          default: sh = 1 + int'($urandom % lw);
        endcase
        s = rnd128();
        if (n % 8 == 3) s = {64{2'b10}};
        run_op(s, rnd128(), size, n[4], n[3], n[2], n[1], n[0], sh, "R1 R2 R3 R4 R5 R6 R7 wide");
      end

    // R7 directed: signed minimum shifted by full width gives all ones
    run_op({2{64'h8000_0000_0000_0000}}, '0, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 64, "R7 sign fill");
    check("R7 sign fill value", out_vec, '1);
    // R2 directed: 64-bit unsigned max rounds to 2^63 without losing carry
    run_op({2{64'hFFFF_FFFF_FFFF_FFFF}}, '0, 3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1, "R2 carry");
    check("R2 carry value", out_vec, {2{64'h8000_0000_0000_0000}});

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    src_vec = {16{8'h40}}; dst_vec = '0; lane_size = 2'd0; wide_reg = 1'b1;
    scalar_mode = 1'b0; sgn_mode = 1'b0; rnd_mode = 1'b0; acc_mode = 1'b0; shift_amt = 7'd2;
    in_valid = 1'b1;
    @(negedge clk);
    src_vec = {16{8'h80}};
    for (int k = 0; k < 4; k++) begin
      check("R9 held valid", {127'd0, out_valid}, 128'd1);
      check("R9 held data", out_vec, {16{8'h10}});
      check("R9 ready low", {127'd0, in_ready}, 128'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next data", out_vec, {16{8'h20}});
    @(negedge clk);
    check("R9 drained", {127'd0, out_valid}, 128'd0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule